// File: doc/BRIEF.md
# Shader Configuration Register Port

This block is the write-side front end of a vertex-shader unit. A producer hands it register writes, one per cycle, each made of a register index, a 32-bit value and a 32-bit bit mask. Every write is merged into the stored register under the mask: bits where the mask is one take the new value, the other bits keep the old one. The merged value then drives the effect tied to that index. It can refresh the sixteen one-bit boolean uniforms. It can refresh one of four integer uniform vectors of four bytes each. It can also append a word to the program memory or to the swizzle-pattern memory.

Each instruction memory is filled through eight aliased data indices that all append at one running offset. The offset steps by one after every append and wraps at the memory depth. Software can write the offset register to start an upload anywhere. The two memory write ports are driven in the same cycle as the accepted write. The uniform outputs change on the clock edge that accepts the write.

A two-state machine governs the handshake. ST_WAKE is entered on reset. In it the port refuses writes (ready low). The transition WAKE_TO_OPEN fires unconditionally on the first clock edge after reset is released. In ST_OPEN the port accepts a write on every cycle in which valid is high. The self-transition OPEN_HOLD keeps it there until the next reset.

Top module: `scp_port`

## Requirements
- R1: While reset is held, and for the first cycle after it is released (ST_WAKE), wr_ready is 0. In that state the boolean uniforms, the integer uniforms and both memory offsets are all zero.
- R2: From the second cycle after reset is released, wr_ready stays 1 (ST_OPEN). A write is accepted in every cycle where wr_valid is 1, back to back, and at most one of prog_we and swz_we is high in any cycle.
- R3: An accepted write stores (old & ~wr_mask) | (wr_value & wr_mask) into the register it addresses. Every effect below uses this merged value.
- R4: Index 0x2B0 holds the boolean uniforms. After an accepted write to it, bool_unif[i] equals bit i of the merged register, for i from 0 to 15, from the next cycle on.
- R5: Indices 0x2B1 to 0x2B4 hold integer uniform n = index - 0x2B1. Uniform n appears on int_unif[32n+31:32n] from the cycle after the write, with x in bits 7:0, y in bits 15:8, z in bits 23:16 and w in bits 31:24 of that slice.
- R6: An accepted write to any of indices 0x2CC to 0x2D3 raises prog_we in the same cycle. In that cycle prog_addr shows the current program offset and prog_data shows the merged value. The program offset then increases by one.
- R7: An accepted write to any of indices 0x2D6 to 0x2DD raises swz_we in the same cycle. In that cycle swz_addr shows the current swizzle offset and swz_data shows the merged value. The swizzle offset then increases by one.
- R8: Index 0x2CB is the program offset register and index 0x2D5 is the swizzle offset register. Both are written under the mask. The next data write to that memory lands at the merged offset (its low 9 or 7 bits).
- R9: The program offset wraps from 511 to 0. The swizzle offset wraps from 127 to 0.
- R10: Writes to any other index, and cycles with wr_valid low, change no uniform and no offset, and raise no memory write.
- R11: Each of the eight aliased data indices of a memory keeps its own stored register. A partial-mask write to one alias merges with the previous value of that same alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A register write is offered |
| wr_ready | output | 1 | The port accepts the offered write |
| wr_index | input | 10 | Register index |
| wr_value | input | 32 | Write value |
| wr_mask | input | 32 | Per-bit write mask, 1 = take new bit |
| bool_unif | output | 16 | Boolean uniforms, bit i = uniform i |
| int_unif | output | 128 | Four integer uniform vectors, 32 bits each |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | 9 | Program memory word address |
| prog_data | output | 32 | Program memory write data |
| swz_we | output | 1 | Swizzle memory write strobe |
| swz_addr | output | 7 | Swizzle memory word address |
| swz_data | output | 32 | Swizzle memory write data |

## Verification
The bench builds the block with its defaults: a 512-word program memory, a 128-word swizzle memory and eight aliases per memory. With these depths, presetting an offset register to 510 or 126 reaches both wrap points (R9) in two appends, without filling either memory. Because all eight aliases are present, alternating partial masks across different aliases shows that each alias keeps its own history (R11), while back-to-back streams cover the shared offset.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [0:0] {
        ST_WAKE = 1'b0,
        ST_OPEN = 1'b1
    } port_state_e;

    // bitwise merge of a register write under its mask
    function automatic logic [31:0] mask_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/scp_uniform_bank.sv
module scp_uniform_bank
    import scp_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int BOOL_N   = 16,
    parameter int BOOL_IDX = 'h2B0,
    parameter int INT_N    = 4,
    parameter int INT_BASE = 'h2B1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [IDX_W-1:0]     idx,
    input  logic [31:0]          value,
    input  logic [31:0]          mask,
    output logic [BOOL_N-1:0]    bool_unif,
    output logic [INT_N*32-1:0]  int_unif
);
    localparam int SW = (INT_N > 1) ? $clog2(INT_N) : 1;

    logic [BOOL_N-1:0] bool_q;
    logic [31:0]       int_q [INT_N];

    logic              bool_hit;
    logic              int_hit;
    logic [SW-1:0]     int_sel;
    logic [31:0]       int_old;
    logic [BOOL_N-1:0] bool_merged;
    logic [31:0]       int_merged;

    always_comb begin
        bool_hit    = acc && (idx == IDX_W'(BOOL_IDX));
        bool_merged = BOOL_N'(mask_merge(32'(bool_q), value, mask));
        int_hit     = 1'b0;
        int_sel     = '0;
        int_old     = '0;
        for (int n = 0; n < INT_N; n++) begin
            if (idx == IDX_W'(INT_BASE + n)) begin
                int_hit = acc;
                int_sel = SW'(n);
                int_old = int_q[n];
            end
        end
        int_merged = mask_merge(int_old, value, mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bool_q <= '0;
            for (int n = 0; n < INT_N; n++) int_q[n] <= '0;
        end else begin
            if (bool_hit) bool_q <= bool_merged;
            if (int_hit)  int_q[int_sel] <= int_merged;
        end
    end

    assign bool_unif = bool_q;

    genvar g;
    generate
        for (g = 0; g < INT_N; g++) begin : g_int_out
            assign int_unif[32*g +: 32] = int_q[g];
        end
    endgenerate

endmodule

// File: rtl/scp_stream_port.sv
module scp_stream_port
    import scp_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int DEPTH    = 512,
    parameter int ALIASES  = 8,
    parameter int BASE_IDX = 'h2CC,
    parameter int OFS_IDX  = 'h2CB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc,
    input  logic [IDX_W-1:0]         idx,
    input  logic [31:0]              value,
    input  logic [31:0]              mask,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_addr,
    output logic [31:0]              mem_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int SW = (ALIASES > 1) ? $clog2(ALIASES) : 1;

    logic [31:0]   alias_q [ALIASES];
    logic [AW-1:0] ofs_q;

    logic          data_hit;
    logic          ofs_hit;
    logic [SW-1:0] sel;
    logic [31:0]   sel_old;
    logic [31:0]   merged;
    logic [AW-1:0] ofs_merged;

    always_comb begin
        data_hit = 1'b0;
        sel      = '0;
        sel_old  = '0;
        for (int a = 0; a < ALIASES; a++) begin
            if (idx == IDX_W'(BASE_IDX + a)) begin
                data_hit = acc;
                sel      = SW'(a);
                sel_old  = alias_q[a];
            end
        end
        ofs_hit    = acc && (idx == IDX_W'(OFS_IDX));
        merged     = mask_merge(sel_old, value, mask);
        ofs_merged = AW'(mask_merge(32'(ofs_q), value, mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
            for (int a = 0; a < ALIASES; a++) alias_q[a] <= '0;
        end else if (data_hit) begin
            alias_q[sel] <= merged;
            ofs_q        <= ofs_q + AW'(1);
        end else if (ofs_hit) begin
            ofs_q <= ofs_merged;
        end
    end

    assign mem_we   = data_hit;
    assign mem_addr = ofs_q;
    assign mem_data = merged;

endmodule

// File: rtl/scp_port.sv
module scp_port
    import scp_pkg::*;
#(
    parameter int IDX_W        = 10,
    parameter int PROG_DEPTH   = 512,
    parameter int SWZ_DEPTH    = 128,
    parameter int N_ALIAS      = 8,
    parameter int BOOL_N       = 16,
    parameter int INT_N        = 4,
    parameter int BOOL_IDX     = 'h2B0,
    parameter int INT_BASE     = 'h2B1,
    parameter int PROG_OFS_IDX = 'h2CB,
    parameter int PROG_BASE    = 'h2CC,
    parameter int SWZ_OFS_IDX  = 'h2D5,
    parameter int SWZ_BASE     = 'h2D6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    input  logic [IDX_W-1:0]              wr_index,
    input  logic [31:0]                   wr_value,
    input  logic [31:0]                   wr_mask,
    output logic [BOOL_N-1:0]             bool_unif,
    output logic [INT_N*32-1:0]           int_unif,
    output logic                          prog_we,
    output logic [$clog2(PROG_DEPTH)-1:0] prog_addr,
    output logic [31:0]                   prog_data,
    output logic                          swz_we,
    output logic [$clog2(SWZ_DEPTH)-1:0]  swz_addr,
    output logic [31:0]                   swz_data
);
    port_state_e state_q, state_d;
    logic        acc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAKE;
        else        state_q <= state_d;
    end

    // transitions: WAKE_TO_OPEN, OPEN_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAKE: state_d = ST_OPEN;
            ST_OPEN: state_d = ST_OPEN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        wr_ready = 1'b0;
        unique case (state_q)
            ST_WAKE: wr_ready = 1'b0;
            ST_OPEN: wr_ready = 1'b1;
        endcase
    end

    assign acc = wr_valid && wr_ready;

    scp_uniform_bank #(
        .IDX_W    (IDX_W),
        .BOOL_N   (BOOL_N),
        .BOOL_IDX (BOOL_IDX),
        .INT_N    (INT_N),
        .INT_BASE (INT_BASE)
    ) u_unif (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .idx       (wr_index),
        .value     (wr_value),
        .mask      (wr_mask),
        .bool_unif (bool_unif),
        .int_unif  (int_unif)
    );

    scp_stream_port #(
        .IDX_W    (IDX_W),
        .DEPTH    (PROG_DEPTH),
        .ALIASES  (N_ALIAS),
        .BASE_IDX (PROG_BASE),
        .OFS_IDX  (PROG_OFS_IDX)
    ) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .idx      (wr_index),
        .value    (wr_value),
        .mask     (wr_mask),
        .mem_we   (prog_we),
        .mem_addr (prog_addr),
        .mem_data (prog_data)
    );

    scp_stream_port #(
        .IDX_W    (IDX_W),
        .DEPTH    (SWZ_DEPTH),
        .ALIASES  (N_ALIAS),
        .BASE_IDX (SWZ_BASE),
        .OFS_IDX  (SWZ_OFS_IDX)
    ) u_swz (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .idx      (wr_index),
        .value    (wr_value),
        .mask     (wr_mask),
        .mem_we   (swz_we),
        .mem_addr (swz_addr),
        .mem_data (swz_data)
    );

endmodule

// File: rtl/scp_port_chk.sv
module scp_port_chk #(
    parameter int PAW   = 9,
    parameter int SAW   = 7,
    parameter int BN    = 16,
    parameter int IW    = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_valid,
    input logic           wr_ready,
    input logic [BN-1:0]  bool_unif,
    input logic [IW-1:0]  int_unif,
    input logic           prog_we,
    input logic [PAW-1:0] prog_addr,
    input logic           swz_we,
    input logic [SAW-1:0] swz_addr
);
    // R6
    prog_we_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> (wr_valid && wr_ready));

    // R7
    swz_we_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swz_we |-> (wr_valid && wr_ready));

    // R9
    prog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> (prog_addr == PAW'($past(prog_addr) + 1'b1)));

    // R9
    swz_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swz_we |=> (swz_addr == SAW'($past(swz_addr) + 1'b1)));

    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_we, swz_we}));

    // R10
    unif_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_ready) |=> ($stable(bool_unif) && $stable(int_unif)));

    // R10
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_ready) |=> ($stable(prog_addr) && $stable(swz_addr)));

    // R1
    closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (!prog_we && !swz_we));

endmodule

bind scp_port scp_port_chk #(
    .PAW ($clog2(PROG_DEPTH)),
    .SAW ($clog2(SWZ_DEPTH)),
    .BN  (BOOL_N),
    .IW  (INT_N*32)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .bool_unif (bool_unif),
    .int_unif  (int_unif),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .swz_we    (swz_we),
    .swz_addr  (swz_addr)
);

// File: tb/scp_port_bench.sv
module scp_port_bench;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [9:0]   wr_index = '0;
    logic [31:0]  wr_value = '0;
    logic [31:0]  wr_mask = '0;
    logic [15:0]  bool_unif;
    logic [127:0] int_unif;
    logic         prog_we;
    logic [8:0]   prog_addr;
    logic [31:0]  prog_data;
    logic         swz_we;
    logic [6:0]   swz_addr;
    logic [31:0]  swz_data;

    always #(PERIOD/2) clk = ~clk;

    scp_port u_scp_port (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_index(wr_index), .wr_value(wr_value), .wr_mask(wr_mask),
        .bool_unif(bool_unif), .int_unif(int_unif),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .swz_we(swz_we), .swz_addr(swz_addr), .swz_data(swz_data)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string phase = "R1";

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          cyc = 0;
    logic [15:0] m_bool = '0;
    logic [31:0] m_int [4];
    logic [31:0] m_pa [8];
    logic [31:0] m_sa [8];
    int          m_pofs = 0;
    int          m_sofs = 0;

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] v, input logic [31:0] m);
        return (o & ~m) | (v & m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_bool = '0; m_pofs = 0; m_sofs = 0;
            for (int k = 0; k < 4; k++) m_int[k] = '0;
            for (int k = 0; k < 8; k++) begin m_pa[k] = '0; m_sa[k] = '0; end
        end else begin
            if (cyc >= 1 && wr_valid) begin
                int i;
                i = int'(wr_index);
                if (i == 'h2B0) m_bool = mrg({16'h0, m_bool}, wr_value, wr_mask) & 32'hFFFF;
                else if (i >= 'h2B1 && i <= 'h2B4) m_int[i-'h2B1] = mrg(m_int[i-'h2B1], wr_value, wr_mask);
                else if (i >= 'h2CC && i <= 'h2D3) begin
                    m_pa[i-'h2CC] = mrg(m_pa[i-'h2CC], wr_value, wr_mask);
                    m_pofs = (m_pofs + 1) % 512;
                end else if (i == 'h2CB) m_pofs = int'(mrg(32'(m_pofs), wr_value, wr_mask) % 512);
                else if (i >= 'h2D6 && i <= 'h2DD) begin
                    m_sa[i-'h2D6] = mrg(m_sa[i-'h2D6], wr_value, wr_mask);
                    m_sofs = (m_sofs + 1) % 128;
                end else if (i == 'h2D5) m_sofs = int'(mrg(32'(m_sofs), wr_value, wr_mask) % 128);
            end
            cyc++;
        end
    end

    // every-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int  i;
            bit  acc, epw, esw;
            i   = int'(wr_index);
            acc = (cyc >= 1) && wr_valid;
            epw = acc && i >= 'h2CC && i <= 'h2D3;
            esw = acc && i >= 'h2D6 && i <= 'h2DD;
            check({phase, "/R1-ready"}, 128'(wr_ready), 128'(cyc >= 1));
            check({phase, "/R4"}, 128'(bool_unif), 128'(m_bool));
            check({phase, "/R5"}, int_unif, {m_int[3], m_int[2], m_int[1], m_int[0]});
            check({phase, "/R6-we"}, 128'(prog_we), 128'(epw));
            check({phase, "/R7-we"}, 128'(swz_we), 128'(esw));
            if (epw) begin
                check({phase, "/R6-addr"}, 128'(prog_addr), 128'(m_pofs));
                check({phase, "/R6-data"}, 128'(prog_data), 128'(mrg(m_pa[i-'h2CC], wr_value, wr_mask)));
            end
            if (esw) begin
                check({phase, "/R7-addr"}, 128'(swz_addr), 128'(m_sofs));
                check({phase, "/R7-data"}, 128'(swz_data), 128'(mrg(m_sa[i-'h2D6], wr_value, wr_mask)));
            end
        end
    end

    // ---------------- stimulus ----------------
    logic        c_pwe, c_swe;
    logic [8:0]  c_pa;
    logic [6:0]  c_sa;
    logic [31:0] c_pd, c_sd;

    task automatic wr(input logic [9:0] i, input logic [31:0] v, input logic [31:0] m);
        wr_valid = 1'b1; wr_index = i; wr_value = v; wr_mask = m;
        @(negedge clk);
        c_pwe = prog_we; c_pa = prog_addr; c_pd = prog_data;
        c_swe = swz_we;  c_sa = swz_addr;  c_sd = swz_data;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD*150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, port closed in ST_WAKE
        check("R1 ready in wake", 128'(wr_ready), 128'(0));
        check("R1 bool reset", 128'(bool_unif), 128'(0));
        check("R1 int reset", int_unif, 128'(0));
        @(posedge clk); #1;
        check("R1 ready after wake", 128'(wr_ready), 128'(1));

        phase = "R4";
        wr(10'h2B0, 32'h0000A5C3, 32'hFFFFFFFF);
        check("R4 bool full write", 128'(bool_unif), 128'(16'hA5C3));
        phase = "R3";
        wr(10'h2B0, 32'h00001234, 32'h0000FF00);
        check("R3 bool masked merge", 128'(bool_unif), 128'(16'h12C3));

        phase = "R5";
        wr(10'h2B3, 32'h44332211, 32'hFFFFFFFF);
        check("R5 uniform 2 slice", 128'(int_unif[95:64]), 128'(32'h44332211));
        check("R5 uniform 2 x", 128'(int_unif[71:64]), 128'(8'h11));
        check("R5 uniform 0 untouched", 128'(int_unif[31:0]), 128'(0));

        phase = "R6";
        wr(10'h2CC, 32'h11112222, 32'hFFFFFFFF);
        check("R6 first we", 128'(c_pwe), 128'(1));
        check("R6 first addr", 128'(c_pa), 128'(0));
        check("R6 first data", 128'(c_pd), 128'(32'h11112222));
        for (int k = 1; k < 8; k++) begin
            wr(10'(32'h2CC + k), 32'hA0000000 + 32'(k), 32'hFFFFFFFF);
            check("R6 alias addr", 128'(c_pa), 128'(k));
        end

        phase = "R11";
        wr(10'h2CC, 32'hDEAD0000, 32'hFFFF0000);
        check("R11 alias0 merge", 128'(c_pd), 128'(32'hDEAD2222));
        check("R11 addr", 128'(c_pa), 128'(8));
        wr(10'h2CD, 32'h00000055, 32'h000000FF);
        check("R11 alias1 merge", 128'(c_pd), 128'(32'hA0000055));

        phase = "R8";
        wr(10'h2CB, 32'h000001FE, 32'hFFFFFFFF);
        wr(10'h2D0, 32'h00000001, 32'hFFFFFFFF);
        check("R8 preset offset", 128'(c_pa), 128'(510));
        phase = "R9";
        wr(10'h2D1, 32'h00000002, 32'hFFFFFFFF);
        check("R9 prog 511", 128'(c_pa), 128'(511));
        wr(10'h2D2, 32'h00000003, 32'hFFFFFFFF);
        check("R9 prog wrap", 128'(c_pa), 128'(0));
        phase = "R8";
        wr(10'h2CB, 32'h00000030, 32'h000000F0);
        wr(10'h2CE, 32'h00000004, 32'hFFFFFFFF);
        check("R8 masked offset", 128'(c_pa), 128'(9'h031));

        phase = "R7";
        wr(10'h2D6, 32'h0000CAFE, 32'hFFFFFFFF);
        check("R7 swz we", 128'(c_swe), 128'(1));
        check("R7 swz addr", 128'(c_sa), 128'(0));
        check("R7 swz data", 128'(c_sd), 128'(32'h0000CAFE));
        check("R7 prog quiet", 128'(c_pwe), 128'(0));
        wr(10'h2DD, 32'h12345678, 32'hFFFFFFFF);
        check("R7 swz step", 128'(c_sa), 128'(1));
        phase = "R9";
        wr(10'h2D5, 32'h0000007F, 32'hFFFFFFFF);
        wr(10'h2D9, 32'h00000010, 32'hFFFFFFFF);
        check("R9 swz 127", 128'(c_sa), 128'(127));
        wr(10'h2D9, 32'h00000011, 32'hFFFFFFFF);
        check("R9 swz wrap", 128'(c_sa), 128'(0));

        phase = "R10";
        wr(10'h2B5, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R10 no write strobe", 128'({c_pwe, c_swe}), 128'(0));
        wr(10'h2CA, 32'hFFFFFFFF, 32'hFFFFFFFF);
        wr(10'h2D4, 32'hFFFFFFFF, 32'hFFFFFFFF);
        wr(10'h2DE, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R10 no write strobe 2", 128'({c_pwe, c_swe}), 128'(0));
        wr_index = 10'h2B0; wr_value = 32'h0; wr_mask = 32'hFFFFFFFF; wr_valid = 1'b0;
        @(posedge clk); #1;
        check("R10 valid low bool", 128'(bool_unif), 128'(16'h12C3));
        wr(10'h2CF, 32'h00000005, 32'hFFFFFFFF);
        check("R10 prog offset kept", 128'(c_pa), 128'(9'h032));
        check("R10 swz offset kept", 128'(swz_addr), 128'(1));

        // R2: back-to-back mixed traffic against the model
        phase = "R2";
        lf = 32'h1234ABCD;
        wr_valid = 1'b1;
        for (int n = 0; n < 400; n++) begin
            logic [9:0] pick [12];
            pick = '{10'h2B0, 10'h2B1, 10'h2B4, 10'h2CB, 10'h2CC, 10'h2D3,
                     10'h2CF, 10'h2D5, 10'h2D6, 10'h2DD, 10'h2D8, 10'h123};
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            wr_index = pick[lf[3:0] % 12];
            wr_valid = (lf[5:4] != 2'b00);
            wr_mask  = lf[7:6] == 2'b00 ? 32'h0000FFFF : (lf[7:6] == 2'b01 ? {lf[15:0], lf[31:16]} : 32'hFFFFFFFF);
            wr_value = {lf[7:0], lf[31:8]};
            @(posedge clk); #1;
        end
        wr_valid = 1'b0;
        @(posedge clk); #1;
        finish_run();
    end

endmodule